// File: doc/BRIEF.md
# Bit-Serial Shift-Add Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product using nothing wider than a one-bit full adder. The carry between bit positions lives in a single flip-flop. A start pulse captures both operands and clears the running product. The block then visits the multiplier bits one at a time, from the least significant bit upward. For each set bit it streams the shifted multiplicand through the one-bit adder into the product accumulator. This takes 2N cycles, one product bit per cycle, and the carry is re-seeded to zero before each pass. A clear multiplier bit costs a single bookkeeping cycle, and the step counter still advances.

When the last step has been handled, the result is copied to the product output and done pulses for one cycle. The output keeps that value until the next multiply completes. A start request that arrives while a multiply is in progress is discarded. The block suits places where area matters more than latency, for example a slow control loop that needs an occasional product.

Top module: `serial_mult`

## Requirements
- R1: While rst_ni is low and after reset is released, product_o reads 0 and done_o reads 0 until a multiply completes.
- R2: After a start accepted with operands A and B, the completed product_o equals A*B as an unsigned 2N-bit value (for example 3*5 gives 15, 255*255 gives 65025 at N=8).
- R3: done_o is high for exactly one clock cycle per accepted start.
- R4: With zero skipping enabled (SKIP_ZERO=1), done_o first reads high exactly 1 + N + 2N*popcount(B) rising edges after the edge that sampled start_i. Each clear bit of B costs one cycle, and each set bit costs 1 + 2N cycles.
- R5: product_o changes only on the cycle in which done_o rises, and holds its value in every other cycle.
- R6: start_i asserted while a multiply is in progress has no effect. The running operation finishes with its original operands and its original latency.
- R7: A start asserted in the cycle where done_o is high is accepted, and a new multiply begins at once.
- R8: A zero multiplicand with a non-zero multiplier still walks every set bit (full R4 latency) and yields 0. A zero multiplier yields 0 after N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply; sampled only when idle |
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned |
| product_o | output | 2N | Last completed product |
| done_o | output | 1 | One-cycle pulse when product_o is updated |

## Verification
A carry flip-flop that is not re-seeded between passes, or an accumulator that is rotated one bit too far or too short, shows up as a wrong product_o. It appears in the very cycle done_o rises, most clearly with a dense multiplier such as all ones. A step or bit counter that is off by one moves the done_o pulse away from the 1 + N + 2N*popcount(B) edge, so cycle-exact latency checks expose control faults even when the arithmetic happens to be right. A controller that leaks start_i while busy either corrupts the result or shortens the latency of the operation in flight, and both are visible at the next done_o.

// File: rtl/serial_mult_pkg.sv
package serial_mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADD,
    ST_FINISH
  } mul_state_e;
endpackage

// File: rtl/serial_mult_bit_adder.sv
// One-bit full adder with the carry held in a flip-flop between cycles.
module serial_mult_bit_adder (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic cin_i,
  input  logic en_i,
  input  logic x_i,
  input  logic y_i,
  output logic sum_o
);
  logic carry_q;
  logic carry_d;

  assign sum_o   = x_i ^ y_i ^ carry_q;
  assign carry_d = (x_i & y_i) | (x_i & carry_q) | (y_i & carry_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     carry_q <= 1'b0;
    else if (init_i) carry_q <= cin_i;
    else if (en_i)   carry_q <= carry_d;
  end
endmodule

// File: rtl/serial_mult_ctrl.sv
module serial_mult_ctrl
  import serial_mult_pkg::*;
#(
  parameter int unsigned N         = 8,
  parameter bit          SKIP_ZERO = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cur_b_i,
  output logic load_o,
  output logic setup_o,
  output logic add_o,
  output logic adv_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned W  = 2 * N;
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned BW = $clog2(W);
  localparam logic [SW-1:0] LAST_STEP = SW'(N - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(W - 1);

  mul_state_e state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic [BW-1:0] bit_q, bit_d;
  logic done_q;
  logic do_pass;

  // Zero multiplier bits either skip the pass or run it with a zero addend.
  generate
    if (SKIP_ZERO) begin : g_skip
      assign do_pass = cur_b_i;
    end else begin : g_full
      assign do_pass = 1'b1;
    end
  endgenerate

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    bit_d    = bit_q;
    load_o   = 1'b0;
    setup_o  = 1'b0;
    add_o    = 1'b0;
    adv_o    = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          step_d  = '0;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (do_pass) begin
          setup_o = 1'b1;
          bit_d   = '0;
          state_d = ST_ADD;
        end else begin
          adv_o = 1'b1;
          if (step_q == LAST_STEP) state_d = ST_FINISH;
          else                     step_d  = step_q + 1'b1;
        end
      end
      ST_ADD: begin
        add_o = 1'b1;
        bit_d = bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          adv_o = 1'b1;
          if (step_q == LAST_STEP) begin
            state_d = ST_FINISH;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = ST_SETUP;
          end
        end
      end
      ST_FINISH: begin
        finish_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      bit_q   <= bit_d;
      done_q  <= finish_o;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/serial_mult_datapath.sv
module serial_mult_datapath #(
  parameter int unsigned N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           setup_i,
  input  logic           add_i,
  input  logic           adv_i,
  input  logic           finish_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic           cur_b_o,
  output logic [2*N-1:0] product_o
);
  localparam int unsigned W = 2 * N;

  logic [W-1:0] a_sh_q;    // multiplicand shifted to the current step weight
  logic [N-1:0] b_sh_q;    // remaining multiplier bits, current one at bit 0
  logic [W-1:0] addend_q;  // streamed LSB first during a pass
  logic [W-1:0] acc_q;     // rotated right one bit per add cycle
  logic [W-1:0] prod_q;
  logic         sum_bit;

  serial_mult_bit_adder u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (setup_i),
    .cin_i  (1'b0),
    .en_i   (add_i),
    .x_i    (acc_q[0]),
    .y_i    (addend_q[0]),
    .sum_o  (sum_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh_q   <= '0;
      b_sh_q   <= '0;
      addend_q <= '0;
      acc_q    <= '0;
      prod_q   <= '0;
    end else begin
      if (load_i) begin
        a_sh_q <= {{N{1'b0}}, a_i};
        b_sh_q <= b_i;
        acc_q  <= '0;
      end else if (adv_i) begin
        a_sh_q <= a_sh_q << 1;
        b_sh_q <= b_sh_q >> 1;
      end
      if (setup_i)    addend_q <= b_sh_q[0] ? a_sh_q : '0;
      else if (add_i) addend_q <= addend_q >> 1;
      if (add_i)      acc_q    <= {sum_bit, acc_q[W-1:1]};
      if (finish_i)   prod_q   <= acc_q;
    end
  end

  assign cur_b_o   = b_sh_q[0];
  assign product_o = prod_q;
endmodule

// File: rtl/serial_mult.sv
module serial_mult #(
  parameter int unsigned N         = 8,
  parameter bit          SKIP_ZERO = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] product_o,
  output logic           done_o
);
  logic load, setup, add, adv, finish, busy, cur_b;

  serial_mult_ctrl #(.N(N), .SKIP_ZERO(SKIP_ZERO)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cur_b_i  (cur_b),
    .load_o   (load),
    .setup_o  (setup),
    .add_o    (add),
    .adv_o    (adv),
    .finish_o (finish),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  serial_mult_datapath #(.N(N)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .setup_i   (setup),
    .add_i     (add),
    .adv_i     (adv),
    .finish_i  (finish),
    .a_i       (a_i),
    .b_i       (b_i),
    .cur_b_o   (cur_b),
    .product_o (product_o)
  );
endmodule

// File: rtl/serial_mult_chk.sv
module serial_mult_chk #(
  parameter int unsigned N         = 8,
  parameter bit          SKIP_ZERO = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_i,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] product_i,
  input logic           done_i
);
  localparam int unsigned W = 2 * N;

  logic [W-1:0]  ref_a, ref_b;
  logic          pend;
  logic [31:0]   lat;
  logic [31:0]   exp_lat;
  logic [W-1:0]  exp_prod;
  logic          accept;

  assign accept   = start_i && !busy_i;
  assign exp_prod = ref_a * ref_b;
  assign exp_lat  = 32'(1 + N) +
                    32'(SKIP_ZERO ? $countones(ref_b) : N) * 32'(W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_a <= '0;
      ref_b <= '0;
      pend  <= 1'b0;
      lat   <= '0;
    end else begin
      if (accept) begin
        ref_a <= {{N{1'b0}}, a_i};
        ref_b <= {{N{1'b0}}, b_i};
        pend  <= 1'b1;
        lat   <= '0;
      end else begin
        if (done_i) pend <= 1'b0;
        if (pend)   lat  <= lat + 1'b1;
      end
    end
  end

  p_result_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> product_i == exp_prod);

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_owed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> pend);

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> lat == exp_lat);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(product_i));

  p_busy_after_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_i);
endmodule

bind serial_mult serial_mult_chk #(.N(N), .SKIP_ZERO(SKIP_ZERO)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_i    (busy),
  .a_i       (a_i),
  .b_i       (b_i),
  .product_i (product_o),
  .done_i    (done_o)
);

// File: tb/sim_serial_mult.sv
`timescale 1ns/1ps
module sim_serial_mult;
  localparam int unsigned N          = 8;
  localparam int unsigned W          = 2 * N;
  localparam time         CLK_PERIOD = 10ns;
  localparam int          WAIT_LIMIT = 2000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic [W-1:0] product;
  logic         done;

  int tests = 0;
  int fails = 0;

  serial_mult #(.N(N), .SKIP_ZERO(1'b1)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .a_i       (a),
    .b_i       (b),
    .product_o (product),
    .done_o    (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [N-1:0] bv);
    int pc = 0;
    for (int i = 0; i < N; i++) pc += int'(bv[i]);
    return 1 + N + pc * W;
  endfunction

  function automatic logic [W-1:0] exp_product(input logic [N-1:0] av, input logic [N-1:0] bv);
    logic [W-1:0] xa, xb;
    xa = {{N{1'b0}}, av};
    xb = {{N{1'b0}}, bv};
    return xa * xb;
  endfunction

  // Drive start for one cycle; returns at the negedge after the sampling edge.
  task automatic launch(input logic [N-1:0] av, input logic [N-1:0] bv);
    a = av;
    b = bv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < WAIT_LIMIT);
  endtask

  task automatic run_one(input logic [N-1:0] av, input logic [N-1:0] bv, input string req);
    int cyc;
    launch(av, bv);
    wait_done(cyc);
    check(done === 1'b1, "R3 done seen", done, 1);
    check(product == exp_product(av, bv), {req, " product"}, product, exp_product(av, bv));
    check(cyc == exp_latency(bv), "R4 latency", cyc, exp_latency(bv));
    @(negedge clk);
    check(done == 1'b0, "R3 single pulse", done, 0);
  endtask

  task automatic t_reset();
    check(product == '0, "R1 product in reset", product, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(product == '0 && done == 1'b0, "R1 after reset", product, 0);
  endtask

  task automatic t_small();
    run_one(8'd3, 8'd5, "R2 3x5");
  endtask

  task automatic t_patterns();
    run_one(8'd13, 8'd11, "R2 13x11");
    run_one(8'hA5, 8'h5A, "R2 a5x5a");
    run_one(8'h01, 8'h80, "R2 1x128");
    run_one(8'h80, 8'h01, "R2 128x1");
  endtask

  task automatic t_extremes();
    run_one(8'hFF, 8'hFF, "R2 max");
    run_one(8'h00, 8'hB7, "R8 zero a");
    run_one(8'hC9, 8'h00, "R8 zero b");
  endtask

  task automatic t_hold();
    logic [W-1:0] snap;
    run_one(8'd200, 8'd7, "R5 setup");
    snap = product;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (product != snap || done) begin
        check(1'b0, "R5 hold", product, snap);
        return;
      end
    end
    check(product == snap, "R5 hold", product, snap);
  endtask

  task automatic t_busy_start();
    int cyc = 0;
    launch(8'd99, 8'h0F);
    do begin
      if (cyc == 3) begin
        a = 8'd7; b = 8'd1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end while (!done && cyc < WAIT_LIMIT);
    start = 1'b0;
    check(product == exp_product(8'd99, 8'h0F), "R6 operands kept", product, exp_product(8'd99, 8'h0F));
    check(cyc == exp_latency(8'h0F), "R6 latency kept", cyc, exp_latency(8'h0F));
    @(negedge clk);
    check(done == 1'b0, "R6 no extra done", done, 0);
    repeat (80) @(negedge clk);
    check(product == exp_product(8'd99, 8'h0F), "R6 no second result", product, exp_product(8'd99, 8'h0F));
  endtask

  task automatic t_back_to_back();
    int cyc;
    launch(8'd17, 8'd3);
    wait_done(cyc);
    check(product == 16'd51, "R7 first", product, 51);
    launch(8'd6, 8'd9);
    wait_done(cyc);
    check(product == 16'd54, "R7 second product", product, 54);
    check(cyc == exp_latency(8'd9), "R7 second latency", cyc, exp_latency(8'd9));
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_small();
    t_patterns();
    t_extremes();
    t_hold();
    t_busy_start();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule